// File: doc/BRIEF.md
# Indirect PHY Command Register Unit

This block is the device-side half of an indirect register path. A host, typically through an MDIO slave front end that turns serial frames into parallel register accesses, reaches a set of internal PHY register banks without addressing them directly. Instead it talks to two registers, a command word and a data word, that answer at one fixed management device address. Writing a command word with its start flag set launches a Clause 22 style read or write against the internal bank. The start flag reads back as busy until the operation is over.

For a write, the unit takes the value already in the data register at the moment the command is accepted and stores it into the target register. For a read, the target value lands in the data register in the same cycle that busy drops. The internal access is modelled with a fixed, parameterised latency. Commands that ask for the other frame mode, or that ask for no operation or for both operations at once, run the same timed sequence but change nothing.

The control is a three-state machine. **IDLE** waits for a command. **WAIT** counts the access latency. **FIN** performs the bank access and the data load, then returns to IDLE. The transitions are **start** (IDLE to WAIT, when a command with the start bit is accepted), **expire** (WAIT to FIN, when the latency counter reaches zero) and **retire** (FIN to IDLE, always after one cycle).

Top module: `indp_cmd_unit`

## Requirements
- R1: After reset the command and data registers read 0, busy reads 0, and register r of internal device d holds {3'b101, d[4:0], 3'b010, r[4:0]}.
- R2: The host registers answer only at management device 0x17: the command register is at offset 0x18 and the data register at 0x19. Any other device or offset reads 0, and writes to it change nothing.
- R3: Command word fields are: bits [4:0] target register, [9:5] target device, bit 10 write, bit 11 read, bit 12 frame mode (1 = Clause 22), bit 15 start/busy. A command written with bit 15 clear is stored and read back, and starts nothing.
- R4: Once a command with bit 15 set is accepted, bit 15 of the command register reads 1 for exactly ACC_LAT+1 cycles, then reads 0.
- R5: For a Clause 22 read, the data register holds the target register value when busy clears.
- R6: For a Clause 22 write, the data register value at the edge that accepts the command is stored into the target register.
- R7: A command with bit 12 clear, or with both or neither of bits 10 and 11 set, changes neither the bank nor the data register, and busy still clears on time.
- R8: A command register write while busy is ignored. The running operation and the stored command word are not affected.
- R9: A data register write while busy is ignored.
- R10: Internal devices span 0x10 to 0x14. A read of any other device returns 0xFFFF, and a write to one stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Host register write strobe |
| acc_dev | input | 5 | Host management device address |
| acc_reg | input | 5 | Host register offset |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Combinational read data for acc_dev/acc_reg |

## Verification
The hardest cases to reach are host writes that land while the machine is in WAIT, because the unit takes them without complaint. If a command or data write slipped through at that point, the damage would only show once busy drops. The stimulus therefore issues a read, writes a competing command and a data word a cycle later, and then checks both the command readback and the returned data after completion. Invalid commands are given a distinctive data value first, so that any stray load or bank write can be seen.

// File: rtl/indp_pkg.sv
package indp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIN  = 2'd2
    } indp_state_e;

    localparam int CMD_START_B = 15;
    localparam int CMD_C22_B   = 12;
    localparam int CMD_RD_B    = 11;
    localparam int CMD_WR_B    = 10;

    // Reset image of the modelled PHY registers
    function automatic logic [15:0] phy_reset_val(input logic [4:0] dev,
                                                  input logic [4:0] ra);
        return {3'b101, dev, 3'b010, ra};
    endfunction

endpackage

// File: rtl/ind_phy_regs.sv
module ind_phy_regs
    import indp_pkg::*;
#(
    parameter logic [4:0] DEV_ID = 5'h10,
    parameter int         DW     = 16,
    parameter int         NREG   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [DW-1:0]           wd,
    input  logic [$clog2(NREG)-1:0] ra,
    output logic [DW-1:0]           rd
);

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= DW'(phy_reset_val(DEV_ID, 5'(i)));
            end
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];

endmodule

// File: rtl/ind_lat_timer.sv
module ind_lat_timer #(
    parameter int LAT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(LAT - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/indp_cmd_unit.sv
module indp_cmd_unit
    import indp_pkg::*;
#(
    parameter logic [4:0] MGMT_DEV = 5'h17,
    parameter logic [4:0] CMD_OFS  = 5'h18,
    parameter logic [4:0] DAT_OFS  = 5'h19,
    parameter logic [4:0] DEV_LO   = 5'h10,
    parameter logic [4:0] DEV_HI   = 5'h14,
    parameter int         ACC_LAT  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_wr,
    input  logic [4:0]  acc_dev,
    input  logic [4:0]  acc_reg,
    input  logic [15:0] acc_wdata,
    output logic [15:0] acc_rdata
);

    localparam int NUM_DEV = int'(DEV_HI) - int'(DEV_LO) + 1;
    localparam int IW      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    indp_state_e st_q, st_d;

    logic [14:0] cmd_q;
    logic [15:0] dat_q;
    logic [4:0]  op_dev_q, op_reg_q;
    logic [15:0] op_val_q;
    logic        op_wr_q, op_rd_q;

    logic        hit_host, busy, cmd_try, cmd_take, dat_take, start;
    logic        tmr_expired, tmr_run;
    logic        bank_we, load_rd, dev_in;
    logic [IW-1:0] dev_idx;
    logic [15:0] bank_rd;
    logic [15:0] bank_rd_arr [NUM_DEV];

    // Host side decode
    assign hit_host = (acc_dev == MGMT_DEV);
    assign busy     = (st_q != ST_IDLE);
    assign cmd_try  = acc_wr && hit_host && (acc_reg == CMD_OFS);
    assign cmd_take = cmd_try && !busy;
    assign dat_take = acc_wr && hit_host && (acc_reg == DAT_OFS) && !busy;
    assign start    = cmd_take && acc_wdata[CMD_START_B];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)       st_d = ST_WAIT;
            ST_WAIT: if (tmr_expired) st_d = ST_FIN;
            ST_FIN:                   st_d = ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        tmr_run = 1'b0;
        bank_we = 1'b0;
        load_rd = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_WAIT: tmr_run = 1'b1;
            ST_FIN: begin
                bank_we = op_wr_q && dev_in;
                load_rd = op_rd_q;
            end
            default: ;
        endcase
    end

    ind_lat_timer #(.LAT(ACC_LAT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    // Host registers and latched operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            dat_q    <= '0;
            op_dev_q <= '0;
            op_reg_q <= '0;
            op_val_q <= '0;
            op_wr_q  <= 1'b0;
            op_rd_q  <= 1'b0;
        end else begin
            if (cmd_take) cmd_q <= acc_wdata[14:0];
            if (start) begin
                op_dev_q <= acc_wdata[9:5];
                op_reg_q <= acc_wdata[4:0];
                op_val_q <= dat_q;
                op_wr_q  <= acc_wdata[CMD_C22_B] && acc_wdata[CMD_WR_B] && !acc_wdata[CMD_RD_B];
                op_rd_q  <= acc_wdata[CMD_C22_B] && acc_wdata[CMD_RD_B] && !acc_wdata[CMD_WR_B];
            end
            if (dat_take)     dat_q <= acc_wdata;
            else if (load_rd) dat_q <= bank_rd;
        end
    end

    // Modelled PHY register banks
    assign dev_in  = (op_dev_q >= DEV_LO) && (op_dev_q <= DEV_HI);
    assign dev_idx = IW'(op_dev_q - DEV_LO);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        ind_phy_regs #(
            .DEV_ID (5'(int'(DEV_LO) + g)),
            .DW     (16),
            .NREG   (32)
        ) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we && (dev_idx == IW'(g))),
            .wa    (op_reg_q),
            .wd    (op_val_q),
            .ra    (op_reg_q),
            .rd    (bank_rd_arr[g])
        );
    end

    assign bank_rd = dev_in ? bank_rd_arr[dev_idx] : 16'hFFFF;

    // Host read mux
    always_comb begin
        acc_rdata = '0;
        if (hit_host && (acc_reg == CMD_OFS))      acc_rdata = {busy, cmd_q};
        else if (hit_host && (acc_reg == DAT_OFS)) acc_rdata = dat_q;
    end

endmodule

// File: rtl/indp_chk.sv
module indp_chk
    import indp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input indp_state_e st,
    input logic [14:0] cmd_q,
    input logic [15:0] dat_q,
    input logic        cmd_try,
    input logic        bank_we,
    input logic        tmr_expired
);

    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && cmd_try |=> $stable(cmd_q));                       // R8

    AST_DATA_FROZEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |=> $stable(dat_q));                                  // R9

    AST_WE_ONLY_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (st == ST_FIN));                                          // R6

    AST_FIN_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIN) |=> (st == ST_IDLE));                                  // R4

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) && !tmr_expired |=> (st == ST_WAIT));                 // R4

endmodule

bind indp_cmd_unit indp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st_q),
    .cmd_q       (cmd_q),
    .dat_q       (dat_q),
    .cmd_try     (cmd_try),
    .bank_we     (bank_we),
    .tmr_expired (tmr_expired)
);

// File: tb/tb_indp_cmd_unit.sv
module tb_indp_cmd_unit;

    localparam int LAT = 16;
    localparam logic [4:0] MG = 5'h17, CR = 5'h18, DR = 5'h19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [4:0]  acc_dev = '0;
    logic [4:0]  acc_reg = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;

    int n_tot = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    indp_cmd_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr    (acc_wr),
        .acc_dev   (acc_dev),
        .acc_reg   (acc_reg),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    function automatic logic [15:0] ref_val(input logic [4:0] d, input logic [4:0] r);
        return {3'b101, d, 3'b010, r};
    endfunction

    function automatic logic [15:0] mk_cmd(input bit st, input bit c22, input bit rd,
                                           input bit wr, input logic [4:0] d,
                                           input logic [4:0] r);
        return {st, 2'b00, c22, rd, wr, d, r};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each queued expectation against the read port
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(acc_rdata === it.exp, it.tag, int'(acc_rdata), int'(it.exp));
        end
    end

    // Driver helpers (each starts and ends on a falling edge)
    task automatic host_wr(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
        acc_dev = d; acc_reg = r; acc_wdata = v; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] d, input logic [4:0] r,
                             input logic [15:0] v, input string tag);
        sb_item_t it;
        acc_dev = d; acc_reg = r;
        it.exp = v; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        acc_dev = MG; acc_reg = CR;
        #1;
        while (acc_rdata[15]) begin
            n++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic phy_read(input logic [4:0] d, input logic [4:0] r);
        int n;
        host_wr(MG, CR, mk_cmd(1, 1, 1, 0, d, r));
        wait_idle(n);
    endtask

    task automatic phy_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
        int n;
        host_wr(MG, DR, v);
        host_wr(MG, CR, mk_cmd(1, 1, 0, 1, d, r));
        wait_idle(n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd(MG, CR, 16'h0000, "R1 cmd reset");
        expect_rd(MG, DR, 16'h0000, "R1 data reset");

        // R4 busy length, R5 read result (also R1 bank image)
        host_wr(MG, CR, mk_cmd(1, 1, 1, 0, 5'h10, 5'h02));
        wait_idle(n);
        chk(n == LAT + 1, "R4 busy cycles", n, LAT + 1);
        expect_rd(MG, DR, ref_val(5'h10, 5'h02), "R5 R1 read dev10 reg2");

        // R6 write then read back
        phy_write(5'h12, 5'h04, 16'hBEEF);
        host_wr(MG, DR, 16'h0000);
        phy_read(5'h12, 5'h04);
        expect_rd(MG, DR, 16'hBEEF, "R6 write dev12 reg4");

        // R6 boundary: last device, last register
        phy_write(5'h14, 5'h1F, 16'h1357);
        host_wr(MG, DR, 16'h0000);
        phy_read(5'h14, 5'h1F);
        expect_rd(MG, DR, 16'h1357, "R6 write dev14 reg31");

        // R3 command without start bit
        host_wr(MG, CR, 16'h0045);
        expect_rd(MG, CR, 16'h0045, "R3 stored, not busy");
        expect_rd(MG, DR, 16'h1357, "R3 no operation");

        // R7 Clause 45 mode selected
        host_wr(MG, DR, 16'h5555);
        host_wr(MG, CR, mk_cmd(1, 0, 0, 1, 5'h13, 5'h01));
        wait_idle(n);
        chk(n == LAT + 1, "R7 busy clears", n, LAT + 1);
        expect_rd(MG, DR, 16'h5555, "R7 c45 data kept");
        phy_read(5'h13, 5'h01);
        expect_rd(MG, DR, ref_val(5'h13, 5'h01), "R7 c45 bank kept");

        // R7 both and neither op bits
        host_wr(MG, DR, 16'h6666);
        host_wr(MG, CR, mk_cmd(1, 1, 1, 1, 5'h13, 5'h01));
        wait_idle(n);
        expect_rd(MG, DR, 16'h6666, "R7 both bits data kept");
        host_wr(MG, CR, mk_cmd(1, 1, 0, 0, 5'h13, 5'h01));
        wait_idle(n);
        expect_rd(MG, DR, 16'h6666, "R7 neither bit data kept");
        phy_read(5'h13, 5'h01);
        expect_rd(MG, DR, ref_val(5'h13, 5'h01), "R7 bank kept");

        // R8 command write while busy
        host_wr(MG, CR, mk_cmd(1, 1, 1, 0, 5'h11, 5'h03));
        host_wr(MG, CR, mk_cmd(1, 1, 1, 0, 5'h12, 5'h05));
        wait_idle(n);
        chk(n == LAT, "R8 run not restarted", n, LAT);
        expect_rd(MG, CR, mk_cmd(0, 1, 1, 0, 5'h11, 5'h03), "R8 cmd word kept");
        expect_rd(MG, DR, ref_val(5'h11, 5'h03), "R8 first op result");

        // R9 data write while busy
        host_wr(MG, CR, mk_cmd(1, 1, 1, 0, 5'h10, 5'h07));
        host_wr(MG, DR, 16'h1234);
        wait_idle(n);
        expect_rd(MG, DR, ref_val(5'h10, 5'h07), "R9 data write ignored");
        host_wr(MG, DR, 16'h0F0F);
        host_wr(MG, CR, mk_cmd(1, 1, 0, 1, 5'h11, 5'h08));
        host_wr(MG, DR, 16'hDEAD);
        wait_idle(n);
        host_wr(MG, DR, 16'h0000);
        phy_read(5'h11, 5'h08);
        expect_rd(MG, DR, 16'h0F0F, "R9 pushed value kept");

        // R2 wrong management device and offset
        host_wr(5'h16, DR, 16'hAAAA);
        host_wr(5'h16, CR, mk_cmd(1, 1, 1, 0, 5'h10, 5'h02));
        expect_rd(MG, CR, mk_cmd(0, 1, 1, 0, 5'h11, 5'h08), "R2 cmd untouched");
        expect_rd(MG, DR, ref_val(5'h11, 5'h08) & 16'h0 | 16'h0F0F, "R2 data untouched");
        expect_rd(5'h16, DR, 16'h0000, "R2 other device reads 0");
        host_wr(MG, 5'h1A, 16'hAAAA);
        expect_rd(MG, 5'h1A, 16'h0000, "R2 other offset reads 0");

        // R10 out-of-range devices
        phy_read(5'h15, 5'h02);
        expect_rd(MG, DR, 16'hFFFF, "R10 dev15 reads FFFF");
        phy_write(5'h0F, 5'h02, 16'h7777);
        phy_read(5'h10, 5'h02);
        expect_rd(MG, DR, ref_val(5'h10, 5'h02), "R10 dev0F write no alias");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
        $finish;
    end

endmodule